// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter, four bits wide by default. It can load a parallel word, count up, count down or hold. Every control input is active-low and takes effect only on the rising clock edge. A load request overrides everything else. Counting needs two separate enables. The first one, the gate enable, only allows counting. The second one, the chain enable, also qualifies the terminal-count output.

The terminal-count output is active-low. It is a combinational decode of the present count, the direction input and the chain enable. Several counters can be connected into one wider synchronous counter. The terminal-count output of each stage drives the chain enable of the next stage. All stages share the clock, the load, the gate enable and the direction. A synchronous active-high reset clears the count to zero so that simulation starts from a known state.

Top module: `updn_counter4`

## Requirements
- R1: While `ld_n` is 0, the next rising edge copies `din` into `q`. This happens for any value of `gate_n`, `chain_in_n` and `up`.
- R2: With `ld_n` at 1, `q` changes on a rising edge only if `gate_n` and `chain_in_n` are both 0.
- R3: When counting is enabled and `up` is 1, `q` increments by one on each edge. The value 2^W-1 (15 by default) wraps to 0.
- R4: When counting is enabled and `up` is 0, `q` decrements by one on each edge. The value 0 wraps to 2^W-1.
- R5: With `ld_n` at 1 and either `gate_n` or `chain_in_n` at 1, `q` keeps its value across the edge.
- R6: `chain_out_n` is 0 exactly when `chain_in_n` is 0 and the count is at its terminal value. The terminal value is all ones when `up` is 1 and zero when `up` is 0. In every other case `chain_out_n` is 1.
- R7: `chain_out_n` does not depend on `gate_n`. A terminal count is still flagged while counting is held off by `gate_n`.
- R8: If `rst` is 1 at a rising edge, `q` becomes 0 on that edge. Reset takes priority over load and count.
- R9: Two stages connected low to high form a 2W-bit synchronous counter. In that arrangement the low stage's `chain_out_n` feeds the high stage's `chain_in_n`, and the combined count moves by one per enabled edge in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear (simulation start-up) |
| ld_n | input | 1 | Active-low parallel load request |
| gate_n | input | 1 | Active-low count enable that does not affect terminal count |
| chain_in_n | input | 1 | Active-low count enable that also qualifies terminal count |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | W | Parallel load data |
| q | output | W | Present count |
| chain_out_n | output | 1 | Active-low terminal count |

## Verification
The bound checker tests the single-stage rules on every cycle:
- load behaviour and its priority over counting;
- increment and decrement by one, including both wraps;
- holding when either enable is inactive;
- the conditions under which `chain_out_n` may go low.

Only the bench scenarios can show how two stages behave together. They show the carry crossing a digit boundary in both directions, the 8-bit wraps, and the terminal count staying asserted while `gate_n` stalls the count. They also check that the stages clear together on reset.

// File: rtl/updn_counter4.sv
module updn_counter4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic         gate_n,
  input  logic         chain_in_n,
  input  logic         up,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         chain_out_n
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  logic run;
  logic at_end;

  assign run    = ~gate_n & ~chain_in_n;
  assign at_end = up ? (q == TOP) : (q == ZERO);
  assign chain_out_n = ~(~chain_in_n & at_end);

  always_ff @(posedge clk) begin
    if (rst)
      q <= ZERO;
    else if (!ld_n)
      q <= din;
    else if (run)
      q <= up ? q + ONE : q - ONE;
  end
endmodule

module updn_counter4_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_n,
  input logic         gate_n,
  input logic         chain_in_n,
  input logic         up,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         chain_out_n
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  a_r1_load_wins: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> q == $past(din));

  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !gate_n && !chain_in_n && up) |=> q == $past(q) + ONE);

  a_r3_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !gate_n && !chain_in_n && up && q == TOP) |=> q == ZERO);

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !gate_n && !chain_in_n && !up) |=> q == $past(q) - ONE);

  a_r4_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !gate_n && !chain_in_n && !up && q == ZERO) |=> q == TOP);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (ld_n && (gate_n || chain_in_n)) |=> $stable(q));

  a_r6_needs_chain: assert property (@(posedge clk) disable iff (rst)
    chain_in_n |-> chain_out_n);

  a_r6_only_at_end: assert property (@(posedge clk) disable iff (rst)
    !chain_out_n |-> (up ? q == TOP : q == ZERO));

  a_r8_clear: assert property (@(posedge clk)
    rst |=> q == ZERO);
endmodule

bind updn_counter4 updn_counter4_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_n(ld_n), .gate_n(gate_n),
  .chain_in_n(chain_in_n), .up(up), .din(din), .q(q),
  .chain_out_n(chain_out_n)
);

// File: tb/updn_counter4_tb.sv
module updn_counter4_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_n = 1'b1, gate_n = 1'b1, trk_n = 1'b1, up = 1'b1;
  logic [7:0] din = 8'h00;
  logic [3:0] q_lo, q_hi;
  logic tc_lo, tc_hi;

  always #(PERIOD/2) clk = ~clk;

  updn_counter4 #(.W(4)) u_dut (
    .clk(clk), .rst(rst), .ld_n(ld_n), .gate_n(gate_n),
    .chain_in_n(trk_n), .up(up), .din(din[3:0]),
    .q(q_lo), .chain_out_n(tc_lo)
  );

  updn_counter4 #(.W(4)) u_dut_hi (
    .clk(clk), .rst(rst), .ld_n(ld_n), .gate_n(gate_n),
    .chain_in_n(tc_lo), .up(up), .din(din[7:4]),
    .q(q_hi), .chain_out_n(tc_hi)
  );

  typedef struct packed {
    logic [7:0] q;
    logic       tl;
    logic       th;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h00;

  task automatic step(input logic r, input logic l, input logic g,
                      input logic t, input logic u, input logic [7:0] d,
                      input string tag);
    exp_t e;
    logic tl;
    @(negedge clk);
    rst = r; ld_n = l; gate_n = g; trk_n = t; up = u; din = d;
    if (r) model = 8'h00;
    else if (!l) model = d;
    else if (!g && !t) model = u ? model + 8'h01 : model - 8'h01;
    tl = ~(~t & (u ? model[3:0] == 4'hF : model[3:0] == 4'h0));
    e.q  = model;
    e.tl = tl;
    e.th = ~(~tl & (u ? model[7:4] == 4'hF : model[7:4] == 4'h0));
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    exp_t  e;
    string tag;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        tag = tag_q.pop_front();
        total += 3;
        if ({q_hi, q_lo} !== e.q) begin
          bad++;
          $display("FAIL %s count: got %h expected %h", tag, {q_hi, q_lo}, e.q);
        end
        if (tc_lo !== e.tl) begin
          bad++;
          $display("FAIL %s low tc: got %b expected %b", tag, tc_lo, e.tl);
        end
        if (tc_hi !== e.th) begin
          bad++;
          $display("FAIL %s high tc: got %b expected %b", tag, tc_hi, e.th);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    // R8: clear, with load and count requests pending
    step(1, 0, 0, 0, 1, 8'hA5, "R8 reset over load");
    step(1, 1, 0, 0, 1, 8'h00, "R8 reset hold");
    // R1: load wins over enabled counting, both directions
    step(0, 0, 0, 0, 1, 8'h0E, "R1 load up-enabled");
    step(0, 0, 0, 0, 0, 8'h3C, "R1 load down-enabled");
    step(0, 0, 1, 1, 1, 8'h0E, "R1 load disabled");
    // R3 and R9: count up across nibble boundaries
    for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 1, 8'h00, "R3 R9 count up");
    // R3 and R9: full 8-bit wrap upward
    step(0, 0, 1, 1, 1, 8'hFD, "R1 load FD");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 1, 8'h00, "R3 R9 wrap up");
    // R4 and R9: count down through 0 and across nibbles
    step(0, 0, 1, 1, 0, 8'h12, "R1 load 12");
    for (int i = 0; i < 24; i++) step(0, 1, 0, 0, 0, 8'h00, "R4 R9 count down");
    // R2 and R5: either enable inactive holds
    step(0, 1, 1, 0, 1, 8'h00, "R5 gate off up");
    step(0, 1, 0, 1, 0, 8'h00, "R2 chain off down");
    step(0, 1, 1, 1, 1, 8'h00, "R5 both off");
    // R7: terminal count seen while gate stalls counting
    step(0, 0, 1, 0, 1, 8'h0F, "R7 load 0F");
    step(0, 1, 1, 0, 1, 8'h00, "R7 stalled at 15 up");
    step(0, 1, 1, 0, 0, 8'h00, "R6 15 in down mode");
    step(0, 1, 1, 1, 1, 8'h00, "R6 chain off at 15");
    step(0, 0, 1, 0, 0, 8'h00, "R7 load 00 down");
    step(0, 1, 1, 0, 0, 8'h00, "R7 stalled at 0 down");
    step(0, 1, 1, 1, 0, 8'h00, "R6 chain off at 0");
    step(0, 1, 1, 0, 1, 8'h00, "R6 0 in up mode");
    step(0, 1, 0, 0, 0, 8'h00, "R4 wrap to FF");
    step(0, 1, 0, 0, 1, 8'h00, "R3 wrap to 00");
    step(1, 1, 0, 0, 1, 8'h00, "R8 reset over count");
    @(negedge clk);
    ld_n = 1'b1; gate_n = 1'b1; trk_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule